// File: doc/BRIEF.md
# Prescaled Modulo Timer with Reload

This block is a memory-mapped 16-bit up-counter for use as a system tick or a one-shot event timer. Software programs a start value and an end (modulo) value. Once counting is switched on, the counter climbs from the start value to the modulo value. On the following tick it returns to the start value and raises an overflow flag. A power-of-two prescaler sets the rate of the counting ticks. The overflow flag can drive an interrupt line, gated by an enable bit.

Four 32-bit word registers sit behind a simple single-cycle register bus.

- The modulo and start-value registers are double-buffered. Bus writes land in a buffer. The values used for counting follow that buffer only while the counter is stopped, so a running period is never disturbed by a write.
- A write of any data to the count register reloads the counter with the start value. The written data is not loaded.
- Software stops the counter, programs the buffers, restarts the count through the count register, then switches counting back on.

Top module: `prescaled_modulo_timer`

## Requirements
- R1: After reset all four registers read 0, `ovfIrq` is low and the counter does not advance.
- R2: With counting on and a divide of 1, the counter advances by 1 on every clock from the start value up to the modulo value. On the next tick it takes the start value instead of incrementing.
- R3: The overflow flag (control word bit 7) sets on the tick where the counter goes from the modulo value to the start value, and not before. A start value S and a modulo M give a period of M - S + 1 ticks.
- R4: Writes to the modulo register (offset 0x8) and the start-value register (offset 0xC) do not change counting while it runs. The new values take effect only after the counter has been stopped for at least one clock. A read of either register returns its last written low 16 bits.
- R5: A bus write of any data to the count register (offset 0x4) sets the counter to the active start value on that clock edge. This reload takes priority over a counting tick in the same cycle.
- R6: The clock-select field (control bits [4:3]) enables counting only at value 1. Values 0, 2 and 3 hold the counter and clear the prescaler divider.
- R7: The prescaler field (control bits [2:0], value P) yields one counting tick every 2^P clocks. The first tick after counting is switched on comes 2^P clocks after the enabling write.
- R8: A control write with bit 7 at 0 clears the overflow flag, and a write with bit 7 at 1 leaves it unchanged. When a flag set and a clearing write fall in the same cycle, the flag ends up set.
- R9: `ovfIrq` is high exactly while the overflow flag and the interrupt-enable bit (control bit 6) are both 1.
- R10: Register offsets are 0x0 control, 0x4 count, 0x8 modulo and 0xC start value. Only the low 16 bits of the count, modulo and start-value registers are kept, and higher read bits and control bit 5 read 0. A write of all ones to the modulo register gives a 16-bit modulo of 0xFFFF, at which the counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the counting source when selected |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | Access is a write (with busSel) |
| busAddr | input | 4 | Byte address; bits [3:2] pick the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| ovfIrq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that a bus write lasts exactly one clock. They also assume that the active modulo and start values change only through the stopped-counter load path, so a held counter is disturbed by nothing but a count-register write. The bench drives every access for one clock from the falling edge. Before each count-register reload it leaves at least one stopped clock, so the active start value has already caught up with its buffer. Whenever the bench writes the control word while a flag must survive, it writes bit 7 as 1. The only clearing write placed on a wrap edge is the deliberate priority case.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

  // Word index taken from the bus address bits [3:2]
  typedef enum logic [1:0] {
    REG_CSR  = 2'd0,
    REG_CNT  = 2'd1,
    REG_MOD  = 2'd2,
    REG_INIT = 2'd3
  } pmt_reg_e;

  // Clock-select codes
  localparam int unsigned SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_STOP = 2'd0;
  localparam logic [SEL_W-1:0] SEL_SYS  = 2'd1;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;        // one counting step this cycle
    logic cntReload;   // count register written: restart from start value
    logic modWr;       // modulo buffer write
    logic initWr;      // start-value buffer write
    logic loadActive;  // counter stopped: active values follow buffers
  } pmt_strobe_t;

endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            run,
  input  logic [PS_W-1:0] psSel,
  output logic            tick
);
  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divMask;

  // Low psSel bits set: terminal when all of them are 1
  assign divMask = ~({DIV_W{1'b1}} << psSel);
  assign tick    = run && ((divCnt & divMask) == divMask);

  always_ff @(posedge clk) begin
    if (!rstN)    divCnt <= '0;
    else if (run) divCnt <= divCnt + DIV_W'(1);
    else          divCnt <= '0;
  end

  // With a divide above 1, ticks never come on two clocks in a row
  AST_PS_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (tick && psSel != '0) |=> (!tick || psSel != $past(psSel))); // R7

endmodule

// File: rtl/pmt_ctrl.sv
module pmt_ctrl
  import pmt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PS_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  pmt_reg_e          regIdx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wrapEvt,
  output pmt_strobe_t       strb,
  output logic              running,
  output logic [DATA_W-1:0] csrWord,
  output logic              irq
);
  localparam int unsigned SEL_LSB  = PS_W;
  localparam int unsigned IE_BIT   = PS_W + SEL_W + 1;
  localparam int unsigned FLAG_BIT = IE_BIT + 1;

  logic [PS_W-1:0]  psSel;
  logic [SEL_W-1:0] clkSel;
  logic             ovfIe;
  logic             ovfFlag;
  logic             csrWr;
  logic             psTick;

  assign csrWr   = regWr && (regIdx == REG_CSR);
  assign running = (clkSel == SEL_SYS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psSel  <= '0;
      clkSel <= SEL_STOP;
      ovfIe  <= 1'b0;
    end else if (csrWr) begin
      psSel  <= wdata[PS_W-1:0];
      clkSel <= wdata[SEL_LSB +: SEL_W];
      ovfIe  <= wdata[IE_BIT];
    end
  end

  // A set on a wrap wins over a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)                           ovfFlag <= 1'b0;
    else if (wrapEvt)                    ovfFlag <= 1'b1;
    else if (csrWr && !wdata[FLAG_BIT])  ovfFlag <= 1'b0;
  end

  pmt_prescaler #(.PS_W(PS_W)) uPrescaler (
    .clk   (clk),
    .rstN  (rstN),
    .run   (running),
    .psSel (psSel),
    .tick  (psTick)
  );

  always_comb begin
    strb.tick       = psTick;
    strb.cntReload  = regWr && (regIdx == REG_CNT);
    strb.modWr      = regWr && (regIdx == REG_MOD);
    strb.initWr     = regWr && (regIdx == REG_INIT);
    strb.loadActive = !running;
  end

  always_comb begin
    csrWord                       = '0;
    csrWord[PS_W-1:0]             = psSel;
    csrWord[SEL_LSB +: SEL_W]     = clkSel;
    csrWord[IE_BIT]               = ovfIe;
    csrWord[FLAG_BIT]             = ovfFlag;
  end

  assign irq = ovfFlag && ovfIe;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> ovfFlag); // R3

  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (csrWr && wdata[SEL_LSB +: SEL_W] != SEL_SYS) |=> !psTick); // R6

endmodule

// File: rtl/pmt_datapath.sv
module pmt_datapath
  import pmt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pmt_strobe_t      strb,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cntValue,
  output logic [CNT_W-1:0] modBuf,
  output logic [CNT_W-1:0] initBuf,
  output logic             wrapEvt
);
  logic [CNT_W-1:0] modActive;
  logic [CNT_W-1:0] initActive;
  logic             atTop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modBuf  <= '0;
      initBuf <= '0;
    end else begin
      if (strb.modWr)  modBuf  <= wdata;
      if (strb.initWr) initBuf <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modActive  <= '0;
      initActive <= '0;
    end else if (strb.loadActive) begin
      modActive  <= modBuf;
      initActive <= initBuf;
    end
  end

  assign atTop   = (cntValue == modActive);
  assign wrapEvt = strb.tick && !strb.cntReload && atTop;

  always_ff @(posedge clk) begin
    if (!rstN)               cntValue <= '0;
    else if (strb.cntReload) cntValue <= initActive;
    else if (strb.tick)      cntValue <= atTop ? initActive : cntValue + CNT_W'(1);
  end

  AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadActive |=> ($stable(modActive) && $stable(initActive))); // R4

  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntReload |=> (cntValue == $past(initActive))); // R5

  AST_WRAP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.cntReload && cntValue == modActive)
      |=> (cntValue == $past(initActive))); // R2

endmodule

// File: rtl/prescaled_modulo_timer.sv
module prescaled_modulo_timer
  import pmt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PS_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              ovfIrq
);
  localparam int unsigned IDX_LSB = 2;

  pmt_reg_e         regIdx;
  logic             regWr;
  pmt_strobe_t      strb;
  logic             running;
  logic             wrapEvt;
  logic [DATA_W-1:0] csrWord;
  logic [CNT_W-1:0] cntValue;
  logic [CNT_W-1:0] modBuf;
  logic [CNT_W-1:0] initBuf;
  logic             unusedBits;

  assign regIdx     = pmt_reg_e'(busAddr[IDX_LSB +: 2]);
  assign regWr      = busSel && busWr;
  assign unusedBits = ^{busWdata[DATA_W-1:CNT_W], busAddr[IDX_LSB-1:0]};

  pmt_ctrl #(.DATA_W(DATA_W), .PS_W(PS_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWr   (regWr),
    .regIdx  (regIdx),
    .wdata   (busWdata),
    .wrapEvt (wrapEvt),
    .strb    (strb),
    .running (running),
    .csrWord (csrWord),
    .irq     (ovfIrq)
  );

  pmt_datapath #(.CNT_W(CNT_W)) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wdata    (busWdata[CNT_W-1:0]),
    .cntValue (cntValue),
    .modBuf   (modBuf),
    .initBuf  (initBuf),
    .wrapEvt  (wrapEvt)
  );

  always_comb begin
    unique case (regIdx)
      REG_CSR:  busRdata = csrWord;
      REG_CNT:  busRdata = DATA_W'(cntValue);
      REG_MOD:  busRdata = DATA_W'(modBuf);
      REG_INIT: busRdata = DATA_W'(initBuf);
      default:  busRdata = '0;
    endcase
  end

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strb.cntReload) |=> $stable(cntValue)); // R6

endmodule

// File: tb/prescaled_modulo_timer_test.sv
module prescaled_modulo_timer_test;

  localparam logic [3:0] A_CSR  = 4'h0;
  localparam logic [3:0] A_CNT  = 4'h4;
  localparam logic [3:0] A_MOD  = 4'h8;
  localparam logic [3:0] A_INIT = 4'hC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        ovfIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  prescaled_modulo_timer uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .ovfIrq(ovfIrq)
  );

  // Called at a falling edge; the write happens on the next rising edge
  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic checkReg(input string req, input string what,
                          input logic [3:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    check(req, what, busRdata, exp);
  endtask

  task automatic testReset;
    checkReg("R1", "csr after reset", A_CSR, 32'h0);
    checkReg("R1", "count after reset", A_CNT, 32'h0);
    checkReg("R1", "modulo after reset", A_MOD, 32'h0);
    checkReg("R1", "start after reset", A_INIT, 32'h0);
    check("R1", "irq after reset", {31'b0, ovfIrq}, 32'h0);
    repeat (4) @(negedge clk);
    checkReg("R1", "count stays stopped", A_CNT, 32'h0);
  endtask

  task automatic testCountWrap;
    busWrite(A_CSR, 32'h0);
    busWrite(A_INIT, 32'd0);
    busWrite(A_MOD, 32'd3);
    busWrite(A_CNT, 32'h5A5A);
    busWrite(A_CSR, 32'h08);
    checkReg("R2", "count before first tick", A_CNT, 32'd0);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      checkReg("R2", "count climbing", A_CNT, k);
    end
    @(negedge clk);
    checkReg("R2", "count wrapped to start", A_CNT, 32'd0);
    busWrite(A_CSR, 32'h80);
  endtask

  task automatic testOverflow;
    busWrite(A_CSR, 32'h0);
    busWrite(A_INIT, 32'd2);
    busWrite(A_MOD, 32'd5);
    busWrite(A_CNT, 32'h0);
    busWrite(A_CSR, 32'h08);
    repeat (3) @(negedge clk);
    checkReg("R3", "count at modulo", A_CNT, 32'd5);
    checkReg("R3", "flag clear at modulo", A_CSR, 32'h08);
    @(negedge clk);
    checkReg("R3", "count back at start", A_CNT, 32'd2);
    checkReg("R3", "flag set after wrap", A_CSR, 32'h88);
    busWrite(A_CSR, 32'h80);
  endtask

  task automatic testFlagPriority;
    busWrite(A_CSR, 32'h0);
    busWrite(A_CSR, 32'h80);
    checkReg("R8", "writing flag 1 does not set it", A_CSR, 32'h0);
    busWrite(A_INIT, 32'd0);
    busWrite(A_MOD, 32'd3);
    busWrite(A_CNT, 32'h0);
    busWrite(A_CSR, 32'h08);
    repeat (3) @(negedge clk);
    busWrite(A_CSR, 32'h08);  // clearing write on the wrap edge
    checkReg("R8", "set wins over clear", A_CSR, 32'h88);
    busWrite(A_CSR, 32'h80);
    checkReg("R8", "flag kept by writing 1", A_CSR, 32'h80);
    busWrite(A_CSR, 32'h00);
    checkReg("R8", "flag cleared by writing 0", A_CSR, 32'h0);
  endtask

  task automatic testIrq;
    busWrite(A_INIT, 32'd0);
    busWrite(A_MOD, 32'd0);
    busWrite(A_CNT, 32'h0);
    busWrite(A_CSR, 32'h08);
    busWrite(A_CSR, 32'h80);  // stop on the edge that wraps
    checkReg("R9", "flag set, enable off", A_CSR, 32'h80);
    check("R9", "irq low without enable", {31'b0, ovfIrq}, 32'h0);
    busWrite(A_CSR, 32'hC0);
    checkReg("R9", "flag and enable", A_CSR, 32'hC0);
    check("R9", "irq high with flag and enable", {31'b0, ovfIrq}, 32'h1);
    busWrite(A_CSR, 32'h40);
    check("R9", "irq low after flag clear", {31'b0, ovfIrq}, 32'h0);
    busWrite(A_CSR, 32'h00);
  endtask

  task automatic testPrescale;
    busWrite(A_CSR, 32'h0);
    busWrite(A_INIT, 32'd0);
    busWrite(A_MOD, 32'd100);
    busWrite(A_CNT, 32'h0);
    busWrite(A_CSR, 32'h0A);  // divide by 4
    repeat (3) @(negedge clk);
    checkReg("R7", "div4 no tick after 3 clocks", A_CNT, 32'd0);
    @(negedge clk);
    checkReg("R7", "div4 first tick after 4 clocks", A_CNT, 32'd1);
    repeat (3) @(negedge clk);
    checkReg("R7", "div4 held between ticks", A_CNT, 32'd1);
    @(negedge clk);
    checkReg("R7", "div4 second tick", A_CNT, 32'd2);
    busWrite(A_CSR, 32'h0);
    busWrite(A_CNT, 32'h0);
    busWrite(A_CSR, 32'h0F);  // divide by 128
    repeat (127) @(negedge clk);
    checkReg("R7", "div128 no tick after 127 clocks", A_CNT, 32'd0);
    @(negedge clk);
    checkReg("R7", "div128 tick after 128 clocks", A_CNT, 32'd1);
    busWrite(A_CSR, 32'h0);
  endtask

  task automatic testStopSel;
    busWrite(A_CSR, 32'h0);
    busWrite(A_INIT, 32'd0);
    busWrite(A_MOD, 32'd100);
    busWrite(A_CNT, 32'h0);
    busWrite(A_CSR, 32'h10);  // select code 2
    repeat (5) @(negedge clk);
    checkReg("R6", "select code 2 holds count", A_CNT, 32'd0);
    busWrite(A_CSR, 32'h18);  // select code 3
    repeat (5) @(negedge clk);
    checkReg("R6", "select code 3 holds count", A_CNT, 32'd0);
    busWrite(A_CSR, 32'h0);
    busWrite(A_CSR, 32'h0A);
    @(negedge clk);
    busWrite(A_CSR, 32'h02);  // stop mid-division
    @(negedge clk);
    checkReg("R6", "no tick before stop", A_CNT, 32'd0);
    busWrite(A_CSR, 32'h0A);
    repeat (3) @(negedge clk);
    checkReg("R6", "divider cleared by stop", A_CNT, 32'd0);
    @(negedge clk);
    checkReg("R6", "full division after restart", A_CNT, 32'd1);
    busWrite(A_CSR, 32'h0);
  endtask

  task automatic testDoubleBuffer;
    busWrite(A_CSR, 32'h0);
    busWrite(A_INIT, 32'd0);
    busWrite(A_MOD, 32'd3);
    busWrite(A_CNT, 32'h0);
    busWrite(A_CSR, 32'h08);
    busWrite(A_MOD, 32'd7);   // while running
    repeat (2) @(negedge clk);
    checkReg("R4", "count at old modulo", A_CNT, 32'd3);
    @(negedge clk);
    checkReg("R4", "wrap at old modulo", A_CNT, 32'd0);
    checkReg("R4", "modulo reads written value", A_MOD, 32'd7);
    busWrite(A_INIT, 32'd5);  // while running
    repeat (3) @(negedge clk);
    checkReg("R4", "wrap to old start", A_CNT, 32'd0);
    checkReg("R4", "start reads written value", A_INIT, 32'd5);
    busWrite(A_CSR, 32'h0);
    @(negedge clk);
    busWrite(A_CNT, 32'h0);
    checkReg("R4", "new start after stop", A_CNT, 32'd5);
    busWrite(A_CSR, 32'h08);
    repeat (2) @(negedge clk);
    checkReg("R4", "count reaches new modulo", A_CNT, 32'd7);
    @(negedge clk);
    checkReg("R4", "wrap at new modulo", A_CNT, 32'd5);
    busWrite(A_CSR, 32'h0);
  endtask

  task automatic testReload;
    busWrite(A_CSR, 32'h0);
    busWrite(A_INIT, 32'h1234);
    busWrite(A_MOD, 32'hFFFF);
    busWrite(A_CNT, 32'hABCD);
    checkReg("R5", "count write loads start not data", A_CNT, 32'h1234);
    busWrite(A_CSR, 32'h08);
    repeat (2) @(negedge clk);
    checkReg("R5", "running before reload", A_CNT, 32'h1236);
    busWrite(A_CNT, 32'h0);
    checkReg("R5", "reload beats tick", A_CNT, 32'h1234);
    @(negedge clk);
    checkReg("R5", "counting resumes from start", A_CNT, 32'h1235);
    busWrite(A_CSR, 32'h0);
  endtask

  task automatic testTruncate;
    busWrite(A_MOD, 32'hFFFF_FFFF);
    checkReg("R10", "modulo keeps low 16 bits", A_MOD, 32'h0000_FFFF);
    busWrite(A_INIT, 32'hABCD_FFFE);
    checkReg("R10", "start keeps low 16 bits", A_INIT, 32'h0000_FFFE);
    @(negedge clk);
    busWrite(A_CNT, 32'h0);
    checkReg("R10", "count zero-extended", A_CNT, 32'h0000_FFFE);
    busWrite(A_CSR, 32'h08);
    @(negedge clk);
    checkReg("R10", "count reaches 0xFFFF", A_CNT, 32'h0000_FFFF);
    @(negedge clk);
    checkReg("R10", "wrap at modulo 0xFFFF", A_CNT, 32'h0000_FFFE);
    busWrite(A_CSR, 32'hFFFF_FF20);
    checkReg("R10", "reserved and upper control bits read 0", A_CSR, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCountWrap();
    testOverflow();
    testFlagPriority();
    testIrq();
    testPrescale();
    testStopSel();
    testDoubleBuffer();
    testReload();
    testTruncate();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule